// File: doc/BRIEF.md
# Deblocking Macroblock Edge Scheduler

This block walks a 4:2:0 picture one macroblock at a time, in raster order, and tells the rest of a deblocking pipeline what to do. For each macroblock it first sorts the position into one of four categories: top-left corner, rest of the top row, rest of the left column, or interior. From that category it issues one fetch window descriptor each for the luma plane and the two chroma planes. Every window includes a 4-sample halo on each side that has a neighbour above or to the left.

It then steps through the internal edges of the macroblock. For each four-sample segment of each edge it reads the supplied strength value once and sends one command to a separate sample filter. When the filter reports idle after both passes, it signals write-back of the macroblock and moves on. After the last macroblock a done flag rises.

The fetch, edge-command and write-back outputs are valid/ready channels. A channel holds valid and its payload unchanged until ready is seen high at a clock edge. A transfer happens at each edge where both are high. Only one channel is active at a time. The strength tables, the start pulse, the frame size and the filter idle flag are plain levels. The strength tables must describe the macroblock shown on the coordinate outputs. Frame dimensions must be at least one macroblock in each direction. The filter idle flag must be low while any accepted command is still in progress.

Top module: `deblk_edge_sched`

## Requirements
- R1: Macroblocks are visited in raster order (x increments first, then y), shown on the coordinate outputs. Each macroblock begins with exactly three fetch descriptors with plane code 0 = luma, 1 = first chroma, 2 = second chroma, in that order.
- R2: Window size in samples (width by height): luma 16x16 at x=0,y=0; 20x16 for x>0,y=0; 16x20 for x=0,y>0; 20x20 otherwise. A chroma window is 8 plus the same 4-sample halo in each direction (8 or 12).
- R3: Window origin is the macroblock's sample position (16 per macroblock for luma, 8 for chroma). A further 4 samples are subtracted in each direction that has a neighbouring macroblock. The origin is 0 in a direction with no neighbour.
- R4: Edge commands of one macroblock come in this order: all vertical edges (direction code 0) before any horizontal edge (code 1). Within a pass the order is luma edges 0..3, then first chroma edges 0..1, then second chroma edges 0..1. Within an edge the segments run 0..3. Edge 0 is the macroblock's left/top boundary.
- R5: No command is issued for vertical edge 0 of a macroblock with x=0, nor for horizontal edge 0 of a macroblock with y=0.
- R6: The strength of luma edge e, segment s comes from bits [3*(4*e+s) +: 3] of the vertical or horizontal table. Chroma edge c uses luma edge 2*c at the same segment index. The command carries that value.
- R7: A segment whose strength is 0 produces no command.
- R8: While a fetch or edge-command valid is high and ready is low, valid and every payload field stay unchanged.
- R9: Write-back valid for a macroblock rises only after its last edge command has been accepted and filter idle has been seen high. There is exactly one write-back per macroblock.
- R10: Done rises after the last macroblock's write-back and stays high with no channel active. A start pulse clears it. A start pulse during a frame has no effect.
- R11: After reset no valid is high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-frame pulse, used only when idle |
| mb_cols_i | input | MB_W | Frame width in macroblocks, captured on start |
| mb_rows_i | input | MB_W | Frame height in macroblocks, captured on start |
| bs_vert_i | input | 48 | Vertical-edge strengths of current macroblock, 3 bits per segment |
| bs_horz_i | input | 48 | Horizontal-edge strengths of current macroblock |
| filt_idle_i | input | 1 | Sample filter has finished every accepted command |
| fch_valid_o | output | 1 | Fetch descriptor valid |
| fch_ready_i | input | 1 | Fetch descriptor ready |
| fch_plane_o | output | 2 | Plane code |
| fch_x_o | output | PIX_W | Window origin x in plane samples |
| fch_y_o | output | PIX_W | Window origin y in plane samples |
| fch_w_o | output | 5 | Window width |
| fch_h_o | output | 5 | Window height |
| cmd_valid_o | output | 1 | Edge command valid |
| cmd_ready_i | input | 1 | Edge command ready |
| cmd_dir_o | output | 1 | 0 vertical, 1 horizontal |
| cmd_plane_o | output | 2 | Plane code |
| cmd_edge_o | output | 2 | Edge index within the plane |
| cmd_seg_o | output | 2 | Segment index along the edge |
| cmd_bs_o | output | 3 | Strength for the segment |
| mb_x_o | output | MB_W | Current macroblock column |
| mb_y_o | output | MB_W | Current macroblock row |
| wb_valid_o | output | 1 | Write-back request for current macroblock |
| wb_ready_i | input | 1 | Write-back accepted |
| done_o | output | 1 | Frame complete |

## Verification
The bound assertions check these properties on every cycle: payloads hold still under back-pressure, no command carries zero strength or lies on a picture border, no vertical command follows a horizontal one within a macroblock, and write-back only follows an idle filter. Only the bench scenarios can show the rest, because it depends on the exact sequence. That covers the full ordered list of descriptors and commands per frame, the window sizes and origins for every category, the per-segment strength lookup including the chroma-to-luma edge mapping, and the stall while the filter stays busy. The same applies to done behaviour across several frame shapes, including a single-macroblock frame and a full 22x18 frame under random back-pressure.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int BS_W    = 3;
  localparam int SEG_N   = 4;
  localparam int Y_EDGES = 4;
  localparam int C_EDGES = 2;
  localparam int N_PLANE = 3;
  localparam int HALO    = 4;
  localparam int TBL_W   = BS_W * SEG_N * Y_EDGES;

  typedef enum logic [1:0] {CAT_CORNER, CAT_TOPROW, CAT_LEFTCOL, CAT_INNER} mbcat_e;
  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_EDGE, ST_DRAIN, ST_WB} state_e;

  function automatic mbcat_e classify(input logic at_left, input logic at_top);
    if (at_left && at_top) return CAT_CORNER;
    if (at_top)            return CAT_TOPROW;
    if (at_left)           return CAT_LEFTCOL;
    return CAT_INNER;
  endfunction

  function automatic logic has_left(input mbcat_e c);
    return (c == CAT_TOPROW) || (c == CAT_INNER);
  endfunction

  function automatic logic has_top(input mbcat_e c);
    return (c == CAT_LEFTCOL) || (c == CAT_INNER);
  endfunction
endpackage

// File: rtl/dbs_mb_walker.sv
module dbs_mb_walker
  import dbs_pkg::*;
#(
  parameter int MB_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic [MB_W-1:0] cols,
  input  logic [MB_W-1:0] rows,
  output logic [MB_W-1:0] mb_x,
  output logic [MB_W-1:0] mb_y,
  output logic            last_mb,
  output mbcat_e          cat
);
  logic [MB_W-1:0] cols_q, rows_q;
  logic            row_end;

  assign row_end = (mb_x == cols_q - MB_W'(1));
  assign last_mb = row_end && (mb_y == rows_q - MB_W'(1));
  assign cat     = classify(mb_x == '0, mb_y == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mb_x   <= '0;
      mb_y   <= '0;
      cols_q <= MB_W'(1);
      rows_q <= MB_W'(1);
    end else if (load) begin
      mb_x   <= '0;
      mb_y   <= '0;
      cols_q <= cols;
      rows_q <= rows;
    end else if (step) begin
      if (row_end) begin
        mb_x <= '0;
        mb_y <= mb_y + MB_W'(1);
      end else begin
        mb_x <= mb_x + MB_W'(1);
      end
    end
  end
endmodule

// File: rtl/dbs_win_gen.sv
module dbs_win_gen
  import dbs_pkg::*;
#(
  parameter int MB_W  = 5,
  parameter int PIX_W = MB_W + 4
) (
  input  logic [MB_W-1:0]  mb_x,
  input  logic [MB_W-1:0]  mb_y,
  input  mbcat_e           cat,
  input  logic [1:0]       plane,
  output logic [PIX_W-1:0] org_x,
  output logic [PIX_W-1:0] org_y,
  output logic [4:0]       size_w,
  output logic [4:0]       size_h
);
  logic [PIX_W-1:0] ox [N_PLANE];
  logic [PIX_W-1:0] oy [N_PLANE];
  logic [4:0]       sw [N_PLANE];
  logic [4:0]       sh [N_PLANE];
  logic             lft, top;

  assign lft = has_left(cat);
  assign top = has_top(cat);

  for (genvar p = 0; p < N_PLANE; p++) begin : g_plane
    localparam int LG   = (p == 0) ? 4 : 3;
    localparam int CORE = 1 << LG;
    logic [PIX_W-1:0] bx, by;
    assign bx    = PIX_W'(mb_x) << LG;
    assign by    = PIX_W'(mb_y) << LG;
    assign ox[p] = lft ? bx - PIX_W'(HALO) : bx;
    assign oy[p] = top ? by - PIX_W'(HALO) : by;
    assign sw[p] = lft ? 5'(CORE + HALO) : 5'(CORE);
    assign sh[p] = top ? 5'(CORE + HALO) : 5'(CORE);
  end

  always_comb begin
    org_x  = ox[0];
    org_y  = oy[0];
    size_w = sw[0];
    size_h = sh[0];
    for (int p = 1; p < N_PLANE; p++) begin
      if (plane == 2'(p)) begin
        org_x  = ox[p];
        org_y  = oy[p];
        size_w = sw[p];
        size_h = sh[p];
      end
    end
  end
endmodule

// File: rtl/dbs_edge_walker.sv
module dbs_edge_walker
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic       dir,
  output logic [1:0] plane,
  output logic [1:0] edge_idx,
  output logic [1:0] seg,
  output logic [1:0] luma_edge,
  output logic       last
);
  logic [1:0] max_edge;

  assign max_edge  = (plane == 2'd0) ? 2'(Y_EDGES - 1) : 2'(C_EDGES - 1);
  assign luma_edge = (plane == 2'd0) ? edge_idx : {edge_idx[0], 1'b0};
  assign last      = dir && (plane == 2'(N_PLANE - 1)) &&
                     (edge_idx == 2'(C_EDGES - 1)) && (seg == 2'(SEG_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir      <= 1'b0;
      plane    <= '0;
      edge_idx <= '0;
      seg      <= '0;
    end else if (adv) begin
      if (seg != 2'(SEG_N - 1)) begin
        seg <= seg + 2'd1;
      end else begin
        seg <= '0;
        if (edge_idx != max_edge) begin
          edge_idx <= edge_idx + 2'd1;
        end else begin
          edge_idx <= '0;
          if (plane != 2'(N_PLANE - 1)) begin
            plane <= plane + 2'd1;
          end else begin
            plane <= '0;
            dir   <= ~dir;
          end
        end
      end
    end
  end
endmodule

// File: rtl/deblk_edge_sched.sv
module deblk_edge_sched
  import dbs_pkg::*;
#(
  parameter int MB_W  = 5,
  parameter int PIX_W = MB_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [MB_W-1:0]  mb_cols_i,
  input  logic [MB_W-1:0]  mb_rows_i,
  input  logic [TBL_W-1:0] bs_vert_i,
  input  logic [TBL_W-1:0] bs_horz_i,
  input  logic             filt_idle_i,
  output logic             fch_valid_o,
  input  logic             fch_ready_i,
  output logic [1:0]       fch_plane_o,
  output logic [PIX_W-1:0] fch_x_o,
  output logic [PIX_W-1:0] fch_y_o,
  output logic [4:0]       fch_w_o,
  output logic [4:0]       fch_h_o,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic             cmd_dir_o,
  output logic [1:0]       cmd_plane_o,
  output logic [1:0]       cmd_edge_o,
  output logic [1:0]       cmd_seg_o,
  output logic [BS_W-1:0]  cmd_bs_o,
  output logic [MB_W-1:0]  mb_x_o,
  output logic [MB_W-1:0]  mb_y_o,
  output logic             wb_valid_o,
  input  logic             wb_ready_i,
  output logic             done_o
);
  state_e     state;
  logic [1:0] fidx;
  logic       done_q;
  logic       mb_load, mb_step, last_mb;
  mbcat_e     cat;
  logic       ew_adv, ew_last, ew_dir;
  logic [1:0] ew_plane, ew_edge, ew_seg, ew_luma_edge;
  logic       on_border, emit;
  logic [BS_W-1:0] seg_bs;
  logic [5:0] bs_lsb;

  assign mb_load = (state == ST_IDLE) && start_i;
  assign mb_step = (state == ST_WB) && wb_ready_i && !last_mb;

  dbs_mb_walker #(.MB_W(MB_W)) i_mb_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mb_load),
    .step    (mb_step),
    .cols    (mb_cols_i),
    .rows    (mb_rows_i),
    .mb_x    (mb_x_o),
    .mb_y    (mb_y_o),
    .last_mb (last_mb),
    .cat     (cat)
  );

  dbs_win_gen #(.MB_W(MB_W), .PIX_W(PIX_W)) i_win_gen (
    .mb_x   (mb_x_o),
    .mb_y   (mb_y_o),
    .cat    (cat),
    .plane  (fidx),
    .org_x  (fch_x_o),
    .org_y  (fch_y_o),
    .size_w (fch_w_o),
    .size_h (fch_h_o)
  );

  dbs_edge_walker i_edge_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (ew_adv),
    .dir       (ew_dir),
    .plane     (ew_plane),
    .edge_idx  (ew_edge),
    .seg       (ew_seg),
    .luma_edge (ew_luma_edge),
    .last      (ew_last)
  );

  // Strength lookup: one table read per four-sample segment.
  assign bs_lsb    = 6'(BS_W) * {2'b00, ew_luma_edge, ew_seg};
  assign seg_bs    = ew_dir ? bs_horz_i[bs_lsb +: BS_W] : bs_vert_i[bs_lsb +: BS_W];
  assign on_border = (ew_luma_edge == 2'd0) &&
                     (ew_dir ? !has_top(cat) : !has_left(cat));
  assign emit      = !on_border && (seg_bs != '0);
  assign ew_adv    = (state == ST_EDGE) && (!emit || cmd_ready_i);

  assign fch_valid_o = (state == ST_FETCH);
  assign fch_plane_o = fidx;
  assign cmd_valid_o = (state == ST_EDGE) && emit;
  assign cmd_dir_o   = ew_dir;
  assign cmd_plane_o = ew_plane;
  assign cmd_edge_o  = ew_edge;
  assign cmd_seg_o   = ew_seg;
  assign cmd_bs_o    = seg_bs;
  assign wb_valid_o  = (state == ST_WB);
  assign done_o      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      fidx   <= '0;
      done_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          state  <= ST_FETCH;
          fidx   <= '0;
          done_q <= 1'b0;
        end
        ST_FETCH: if (fch_ready_i) begin
          if (fidx == 2'(N_PLANE - 1)) state <= ST_EDGE;
          else                         fidx  <= fidx + 2'd1;
        end
        ST_EDGE: if (ew_adv && ew_last) state <= ST_DRAIN;
        ST_DRAIN: if (filt_idle_i) state <= ST_WB;
        ST_WB: if (wb_ready_i) begin
          if (last_mb) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= ST_FETCH;
            fidx  <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbs_sched_chk.sv
module dbs_sched_chk #(
  parameter int MB_W  = 5,
  parameter int PIX_W = MB_W + 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             filt_idle_i,
  input logic             fch_valid_o,
  input logic             fch_ready_i,
  input logic [1:0]       fch_plane_o,
  input logic [PIX_W-1:0] fch_x_o,
  input logic [PIX_W-1:0] fch_y_o,
  input logic [4:0]       fch_w_o,
  input logic [4:0]       fch_h_o,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic             cmd_dir_o,
  input logic [1:0]       cmd_plane_o,
  input logic [1:0]       cmd_edge_o,
  input logic [1:0]       cmd_seg_o,
  input logic [2:0]       cmd_bs_o,
  input logic [MB_W-1:0]  mb_x_o,
  input logic [MB_W-1:0]  mb_y_o,
  input logic             wb_valid_o,
  input logic             wb_ready_i,
  input logic             done_o
);
  logic seen_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seen_h <= 1'b0;
    else if (wb_valid_o && wb_ready_i)            seen_h <= 1'b0;
    else if (cmd_valid_o && cmd_ready_i && cmd_dir_o) seen_h <= 1'b1;
  end

  p_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fch_valid_o && !fch_ready_i |=> fch_valid_o && $stable(fch_plane_o) &&
      $stable(fch_x_o) && $stable(fch_y_o) && $stable(fch_w_o) && $stable(fch_h_o));

  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_dir_o) &&
      $stable(cmd_plane_o) && $stable(cmd_edge_o) && $stable(cmd_seg_o) && $stable(cmd_bs_o));

  p_vert_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && seen_h |-> cmd_dir_o);

  p_left_border_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_dir_o && cmd_edge_o == 2'd0 |-> mb_x_o != '0);

  p_top_border_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && cmd_dir_o && cmd_edge_o == 2'd0 |-> mb_y_o != '0);

  p_nonzero_bs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> cmd_bs_o != 3'd0);

  p_origin_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fch_valid_o && mb_x_o == '0 |-> fch_x_o == '0);

  p_wb_after_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid_o) |-> $past(filt_idle_i));

  p_one_channel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fch_valid_o, cmd_valid_o, wb_valid_o}) <= 1);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !fch_valid_o && !cmd_valid_o && !wb_valid_o);
endmodule

bind deblk_edge_sched dbs_sched_chk #(.MB_W(MB_W), .PIX_W(PIX_W)) i_chk (.*);

// File: tb/test_deblk_edge_sched.sv
`timescale 1ns/1ps
module test_deblk_edge_sched;
  localparam int MB_W  = 5;
  localparam int PIX_W = MB_W + 4;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [MB_W-1:0] mb_cols_i = '0, mb_rows_i = '0;
  logic [47:0] bs_vert_i, bs_horz_i;
  logic filt_idle_i, fch_ready_i, cmd_ready_i, wb_ready_i;
  logic fch_valid_o, cmd_valid_o, wb_valid_o, done_o, cmd_dir_o;
  logic [1:0] fch_plane_o, cmd_plane_o, cmd_edge_o, cmd_seg_o;
  logic [PIX_W-1:0] fch_x_o, fch_y_o;
  logic [4:0] fch_w_o, fch_h_o;
  logic [2:0] cmd_bs_o;
  logic [MB_W-1:0] mb_x_o, mb_y_o;

  int vectors = 0, errors = 0, cycles = 0;
  logic bp = 1'b0, hold_busy = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] q_fch[$], q_cmd[$], q_wb[$];
  logic stall_q = 1'b0;
  logic [31:0] stall_item;

  always #5 clk = ~clk;

  deblk_edge_sched #(.MB_W(MB_W), .PIX_W(PIX_W)) i_deblk_edge_sched (.*);

  function automatic logic [2:0] bsf(int x, int y, int d, int e, int s);
    return 3'((x * 3 + y * 5 + e * 7 + s + d * 2) % 5);
  endfunction

  always_comb begin
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 4; s++) begin
        bs_vert_i[3*(4*e+s) +: 3] = bsf(int'(mb_x_o), int'(mb_y_o), 0, e, s);
        bs_horz_i[3*(4*e+s) +: 3] = bsf(int'(mb_x_o), int'(mb_y_o), 1, e, s);
      end
  end

  assign fch_ready_i = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
  assign cmd_ready_i = bp ? (lfsr[1] | lfsr[5]) : 1'b1;
  assign wb_ready_i  = bp ? lfsr[2] : 1'b1;
  assign filt_idle_i = hold_busy ? 1'b0 : (bp ? (lfsr[4] | lfsr[7]) : 1'b1);

  always @(posedge clk) begin
    #1 lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  function automatic logic [31:0] pk_fch(int p, int x, int y, int w, int h);
    return {2'(p), 10'(x), 10'(y), 5'(w), 5'(h)};
  endfunction
  function automatic logic [31:0] pk_cmd(int x, int y, int d, int p, int e, int s, int b);
    return {12'd0, 5'(x), 5'(y), 1'(d), 2'(p), 2'(e), 2'(s), 3'(b)};
  endfunction

  // Driver side of the scoreboard: expected items from the requirements.
  task automatic push_frame(int cols, int rows);
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < cols; x++) begin
        for (int p = 0; p < 3; p++) begin
          int sc = (p == 0) ? 16 : 8;
          q_fch.push_back(pk_fch(p, x * sc - (x > 0 ? 4 : 0), y * sc - (y > 0 ? 4 : 0),
                                 sc + (x > 0 ? 4 : 0), sc + (y > 0 ? 4 : 0)));
        end
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 3; p++)
            for (int e = 0; e < ((p == 0) ? 4 : 2); e++)
              for (int s = 0; s < 4; s++) begin
                int le = (p == 0) ? e : 2 * e;
                bit border = (le == 0) && ((d == 0) ? (x == 0) : (y == 0));
                int b = int'(bsf(x, y, d, le, s));
                if (!border && b != 0) q_cmd.push_back(pk_cmd(x, y, d, p, e, s, b));
              end
        q_wb.push_back({22'd0, 5'(x), 5'(y)});
      end
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor side of the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] a, e;
      if (fch_valid_o && fch_ready_i) begin
        a = pk_fch(int'(fch_plane_o), int'(fch_x_o), int'(fch_y_o), int'(fch_w_o), int'(fch_h_o));
        e = (q_fch.size() > 0) ? q_fch.pop_front() : 32'hFFFF_FFFF;
        check(a == e, "R1 R2 R3", "fetch descriptor", a, e);
      end
      a = pk_cmd(int'(mb_x_o), int'(mb_y_o), int'(cmd_dir_o), int'(cmd_plane_o),
                 int'(cmd_edge_o), int'(cmd_seg_o), int'(cmd_bs_o));
      if (stall_q) check(cmd_valid_o && a == stall_item, "R8", "command held under stall", a, stall_item);
      stall_q    = cmd_valid_o && !cmd_ready_i;
      stall_item = a;
      if (cmd_valid_o && cmd_ready_i) begin
        e = (q_cmd.size() > 0) ? q_cmd.pop_front() : 32'hFFFF_FFFF;
        check(a == e, "R4 R5 R6 R7", "edge command", a, e);
      end
      if (wb_valid_o && wb_ready_i) begin
        a = {22'd0, mb_x_o, mb_y_o};
        e = (q_wb.size() > 0) ? q_wb.pop_front() : 32'hFFFF_FFFF;
        check(a == e, "R9", "write-back macroblock", a, e);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic run_frame(int cols, int rows, bit mid_start);
    push_frame(cols, rows);
    @(posedge clk); #1;
    mb_cols_i = MB_W'(cols);
    mb_rows_i = MB_W'(rows);
    pulse_start();
    @(negedge clk);
    check(done_o == 1'b0, "R10", "done cleared by start", 32'(done_o), 0);
    if (mid_start) begin
      repeat (30) @(posedge clk);
      pulse_start();   // R10: ignored while busy; scoreboard would see extra items
    end
    while (!done_o) @(negedge clk);
    check(q_fch.size() == 0, "R1", "fetch items left", q_fch.size(), 0);
    check(q_cmd.size() == 0, "R4", "commands left", q_cmd.size(), 0);
    check(q_wb.size() == 0, "R9", "write-backs left", q_wb.size(), 0);
    repeat (5) @(negedge clk);
    check(done_o && !fch_valid_o && !cmd_valid_o && !wb_valid_o, "R10", "done holds quiet",
          32'(done_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!fch_valid_o && !cmd_valid_o && !wb_valid_o && !done_o, "R11", "reset outputs",
          {fch_valid_o, cmd_valid_o, wb_valid_o, done_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!fch_valid_o && !done_o, "R11", "after reset release", {fch_valid_o, done_o}, 0);

    run_frame(3, 2, 1'b0);
    run_frame(1, 1, 1'b0);
    bp = 1'b1;
    run_frame(4, 3, 1'b1);

    // R9: filter busy keeps write-back back.
    bp = 1'b0;
    hold_busy = 1'b1;
    push_frame(2, 1);
    @(posedge clk); #1;
    mb_cols_i = MB_W'(2);
    mb_rows_i = MB_W'(1);
    pulse_start();
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (wb_valid_o) seen = 1'b1;
      end
      check(!seen && q_cmd.size() > 0 && !done_o, "R9", "write-back held while busy", 32'(seen), 0);
    end
    hold_busy = 1'b0;
    while (!done_o) @(negedge clk);
    check(q_cmd.size() == 0 && q_wb.size() == 0, "R9", "queues drained after busy",
          q_cmd.size() + q_wb.size(), 0);

    bp = 1'b1;
    run_frame(22, 18, 1'b0);
    finish_run();
  end
endmodule